// File: doc/BRIEF.md
# Dual-CPU Cache Pool Mux

Two CPUs share two internal memory pools. Each pool can hold cache line storage for one CPU, or it can act as plain instruction RAM. This block decides which CPU owns each pool and routes each CPU's access port to the pool that serves it. A 2-bit mode register selects the mapping:

- **Mode 0:** each CPU keeps its own pool as cache.
- **Modes 1 and 2:** both CPUs compete for one shared pool. Only one of them may have its cache turned on at any time.
- **Mode 3:** reserved. It gives the mode 0 mapping.

A pool that no enabled cache has claimed is served as RAM. Several kinds of misuse are refused and latch a sticky error flag:

- changing the mode while any cache is on;
- a second cache enable in a shared mode.

Pool ownership is held in registers. An owner can therefore only change on a clock edge, never in the middle of an access. The tag and line-fill logic of the caches sits outside this block. It reaches the pool storage through the cache-access flavour of each CPU port.

Top module: `cache_pool_mux`

## Requirements
- R1: After a synchronous active-low reset:
  - `mode_q` is 0;
  - `cache_on` is 0;
  - both pool roles are RAM (role code 0);
  - `cfg_err` is 0.
- R2: In mode 0, `cache_on[c]` takes the value of `cache_req[c]` one cycle later. Pool 0 carries role 1 (cache of CPU0) while `cache_on[0]` is high, and role 0 otherwise. Pool 1 carries role 2 (cache of CPU1) while `cache_on[1]` is high, and role 0 otherwise. Each pool's role is the 2-bit field at bits [2p+1:2p] of `pool_role`.
- R3: In mode 1, pool 0 is the shared pool. In mode 2, pool 1 is the shared pool. The shared pool carries role 1 or 2 according to which CPU has its cache on, or role 0 when neither does. The other pool always carries role 0 (RAM).
- R4: In modes 1 and 2, at most one bit of `cache_on` is ever high. A CPU's enable request is refused, and `cfg_err` is set, only in these cases:
  - the other CPU holds its enable and keeps requesting;
  - both CPUs request from idle in the same cycle. CPU0 is granted and CPU1 is refused.

  A holder that drops its request hands over in the same cycle.
- R5: A write on `mode_wr` takes effect on the next edge only while `cache_on` is 0. Otherwise the mode is kept and `cfg_err` is set. `cfg_err` stays high until reset.
- R6: Mode value 3 is stored and read back as 3. Its pool roles and cache routing are those of mode 0.
- R7: `pool_role` and `cache_on` are registered.
  - Input changes inside a cycle leave them unchanged.
  - `pool_role` always matches the role implied by `mode_q` and `cache_on`.
- R8: A cache access (`cpu_cache[c]`=1) is granted only while that CPU's cache is on. It goes to the CPU's cache pool: pool c in modes 0 and 3, otherwise the shared pool. The pool port receives its write enable, address and write data unchanged.
- R9: A RAM access (`cpu_cache[c]`=0) names its pool in `cpu_pool[c]`. It is granted only while that pool carries role 0. When both CPUs ask for the same RAM pool in one cycle, CPU0 is granted and CPU1 is not.
- R10: One cycle after a granted read (`cpu_we`=0), `cpu_rvalid[c]` is high. `cpu_rdata[c]` then carries the current `pool_rdata` of the pool that was read. After a write, a refused access or an idle cycle, `cpu_rvalid[c]` is low.
- R11: `pool_en[p]` is high exactly when some CPU's access is granted to pool p. A pool is never driven by two CPUs in one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mode_wr | input | 1 | Mode register write strobe |
| mode_wdata | input | 2 | New mode value |
| cache_req | input | 2 | Per-CPU cache enable request, bit c for CPU c |
| cpu_req | input | 2 | Per-CPU access request |
| cpu_cache | input | 2 | 1 = cache storage access, 0 = RAM access |
| cpu_pool | input | 2 | Target pool index for a RAM access, bit c for CPU c |
| cpu_we | input | 2 | Per-CPU write enable |
| cpu_addr | input | 2*ADDR_W | Per-CPU word address, CPU c at [c*ADDR_W +: ADDR_W] |
| cpu_wdata | input | 2*DATA_W | Per-CPU write data |
| cpu_gnt | output | 2 | Access granted this cycle |
| cpu_rvalid | output | 2 | Read data valid (one cycle after a granted read) |
| cpu_rdata | output | 2*DATA_W | Read data returned to each CPU |
| pool_en | output | 2 | Pool port enable |
| pool_we | output | 2 | Pool port write enable |
| pool_addr | output | 2*ADDR_W | Pool port address |
| pool_wdata | output | 2*DATA_W | Pool port write data |
| pool_rdata | input | 2*DATA_W | Pool read data, valid one cycle after enable |
| pool_role | output | 4 | Registered role per pool: 0 RAM, 1 cache of CPU0, 2 cache of CPU1 |
| mode_q | output | 2 | Current mode |
| cache_on | output | 2 | Effective per-CPU cache enable |
| cfg_err | output | 1 | Sticky configuration error |

## Verification
Several properties are checked on every cycle by assertions:
- no two cache enables coexist in a shared mode;
- the mode is locked and the error is latched when a write arrives while a cache is on;
- the error never clears;
- each pool role agrees with the stored mode and enables;
- CPU0 wins a shared RAM pool;
- a granted read returns a valid strobe.

Only the bench scenarios can show the rest:
- which CPU wins a simultaneous enable;
- the same-cycle handover between CPUs;
- mode 3 behaving like mode 0;
- roles staying fixed while inputs change mid-cycle;
- exact address, data and read-return routing against an independent model under random traffic.

// File: rtl/cpm_pkg.sv
// Package: shared constants, pool role codes and the mode decode helpers
// used by both the configuration and the routing logic.
// Assumes exactly two CPUs and two pools.
package cpm_pkg;
    localparam int N_CPU  = 2;
    localparam int N_POOL = 2;
    localparam int MODE_W = 2;
    localparam int ROLE_W = 2;

    typedef enum logic [ROLE_W-1:0] {
        ROLE_RAM    = 2'd0,
        ROLE_CACHE0 = 2'd1,
        ROLE_CACHE1 = 2'd2
    } role_e;

    // True for the two modes in which both CPUs compete for one pool
    function automatic logic shared_mode(input logic [MODE_W-1:0] m);
        return (m == 2'd1) || (m == 2'd2);
    endfunction

    // Pool that holds the cache lines of the given CPU under mode m
    function automatic logic cache_pool(input logic [MODE_W-1:0] m, input logic cpu);
        if (m == 2'd1) return 1'b0;
        if (m == 2'd2) return 1'b1;
        return cpu;
    endfunction

    // Role a pool takes for a given mode and set of enabled caches
    function automatic logic [ROLE_W-1:0] pool_role_of(input logic [MODE_W-1:0] m,
                                                      input logic [N_CPU-1:0] en,
                                                      input logic p);
        if (shared_mode(m)) begin
            if (p != cache_pool(m, 1'b0)) return ROLE_RAM;
            if (en[0]) return ROLE_CACHE0;
            if (en[1]) return ROLE_CACHE1;
            return ROLE_RAM;
        end
        if (!en[p]) return ROLE_RAM;
        return p ? ROLE_CACHE1 : ROLE_CACHE0;
    endfunction
endpackage

// File: rtl/cpm_cfg.sv
// Module: cpm_cfg
// Holds the mode register and the effective cache enables, and registers
// the role of each pool.
// - A mode write is taken only while both caches are off.
// - In a shared mode at most one cache may be on.
// - Refused requests latch a sticky error.
// Roles are computed from the next-state values, so they change only on a
// clock edge and always agree with mode_q and cache_on.
// Assumes two CPUs and two pools.
module cpm_cfg
    import cpm_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     mode_wr,
    input  logic [MODE_W-1:0]        mode_wdata,
    input  logic [N_CPU-1:0]         cache_req,
    output logic [MODE_W-1:0]        mode_q,
    output logic [N_CPU-1:0]         cache_on,
    output logic [N_POOL*ROLE_W-1:0] role_q,
    output logic                     cfg_err
);
    logic [MODE_W-1:0]        mode_d;
    logic [N_CPU-1:0]         en_d;
    logic [N_POOL*ROLE_W-1:0] role_d;
    logic                     mode_err;
    logic                     en_err;

    // Next mode: accepted only with every cache off
    always_comb begin
        mode_err = mode_wr && (cache_on != '0);
        mode_d   = (mode_wr && !mode_err) ? mode_wdata : mode_q;
    end

    // Next enables: free in mode 0/3, one-at-a-time interlock in shared modes
    always_comb begin
        en_err = 1'b0;
        if (!shared_mode(mode_d)) begin
            en_d = cache_req;
        end else if (cache_on[0] && cache_req[0]) begin
            en_d   = 2'b01;
            en_err = cache_req[1];
        end else if (cache_on[1] && cache_req[1]) begin
            en_d   = 2'b10;
            en_err = cache_req[0];
        end else if (cache_req[0]) begin
            en_d   = 2'b01;
            en_err = cache_req[1];
        end else begin
            en_d = cache_req;
        end
    end

    // Next pool roles from the next mode and enables
    always_comb begin
        for (int p = 0; p < N_POOL; p++) begin
            role_d[p*ROLE_W +: ROLE_W] = pool_role_of(mode_d, en_d, 1'(p));
        end
    end

    // State update with synchronous reset; error is sticky
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q   <= '0;
            cache_on <= '0;
            role_q   <= '0;
            cfg_err  <= 1'b0;
        end else begin
            mode_q   <= mode_d;
            cache_on <= en_d;
            role_q   <= role_d;
            cfg_err  <= cfg_err | mode_err | en_err;
        end
    end

    assert_shared_one_R4: assert property (@(posedge clk) disable iff (!rst_n)
        shared_mode(mode_q) |-> (cache_on != 2'b11));

    assert_mode_lock_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_wr && cache_on != '0) |=> ($stable(mode_q) && cfg_err));

    assert_err_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |=> cfg_err);

    for (genvar p = 0; p < N_POOL; p++) begin : g_role_chk
        assert_role_match_R7: assert property (@(posedge clk) disable iff (!rst_n)
            role_q[p*ROLE_W +: ROLE_W] == pool_role_of(mode_q, cache_on, 1'(p)));
    end
endmodule

// File: rtl/cpm_router.sv
// Module: cpm_router
// Routes each CPU access port to a pool, using the registered pool roles.
// - A cache access goes to the CPU's cache pool and needs that pool to be
//   this CPU's cache.
// - A RAM access names its pool and needs that pool to be RAM.
// - On a tie for one pool the lower CPU index wins.
// Pool storage is assumed to return read data one cycle after its enable,
// so the read-return mux uses a registered pool index per CPU.
module cpm_router
    import cpm_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [MODE_W-1:0]        mode_q,
    input  logic [N_POOL*ROLE_W-1:0] role_q,
    input  logic [N_CPU-1:0]         cpu_req,
    input  logic [N_CPU-1:0]         cpu_cache,
    input  logic [N_CPU-1:0]         cpu_pool,
    input  logic [N_CPU-1:0]         cpu_we,
    input  logic [N_CPU*ADDR_W-1:0]  cpu_addr,
    input  logic [N_CPU*DATA_W-1:0]  cpu_wdata,
    output logic [N_CPU-1:0]         cpu_gnt,
    output logic [N_CPU-1:0]         cpu_rvalid,
    output logic [N_CPU*DATA_W-1:0]  cpu_rdata,
    output logic [N_POOL-1:0]        pool_en,
    output logic [N_POOL-1:0]        pool_we,
    output logic [N_POOL*ADDR_W-1:0] pool_addr,
    output logic [N_POOL*DATA_W-1:0] pool_wdata,
    input  logic [N_POOL*DATA_W-1:0] pool_rdata
);
    logic [N_CPU-1:0] tgt;
    logic [N_CPU-1:0] ok;

    // Target pool and eligibility of each CPU's access
    always_comb begin
        logic [ROLE_W-1:0] want;
        for (int c = 0; c < N_CPU; c++) begin
            tgt[c] = cpu_cache[c] ? cache_pool(mode_q, 1'(c)) : cpu_pool[c];
            want   = cpu_cache[c] ? ((c == 0) ? ROLE_CACHE0 : ROLE_CACHE1) : ROLE_RAM;
            ok[c]  = cpu_req[c] && (role_q[int'(tgt[c])*ROLE_W +: ROLE_W] == want);
        end
    end

    // Fixed priority: a CPU loses to any lower-index CPU granted the same pool
    always_comb begin
        for (int c = 0; c < N_CPU; c++) begin
            cpu_gnt[c] = ok[c];
            for (int k = 0; k < c; k++) begin
                if (ok[k] && tgt[k] == tgt[c]) cpu_gnt[c] = 1'b0;
            end
        end
    end

    // Pool port drive from the granted CPU (lowest index last wins the mux)
    always_comb begin
        pool_en    = '0;
        pool_we    = '0;
        pool_addr  = '0;
        pool_wdata = '0;
        for (int p = 0; p < N_POOL; p++) begin
            for (int c = N_CPU-1; c >= 0; c--) begin
                if (cpu_gnt[c] && tgt[c] == 1'(p)) begin
                    pool_en[p]                     = 1'b1;
                    pool_we[p]                     = cpu_we[c];
                    pool_addr[p*ADDR_W +: ADDR_W]  = cpu_addr[c*ADDR_W +: ADDR_W];
                    pool_wdata[p*DATA_W +: DATA_W] = cpu_wdata[c*DATA_W +: DATA_W];
                end
            end
        end
    end

    for (genvar c = 0; c < N_CPU; c++) begin : g_ret
        logic rv_q;
        logic rp_q;

        // Remember a granted read and its pool for the next cycle's return
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rv_q <= 1'b0;
                rp_q <= 1'b0;
            end else begin
                rv_q <= cpu_gnt[c] && !cpu_we[c];
                rp_q <= tgt[c];
            end
        end

        assign cpu_rvalid[c]                 = rv_q;
        assign cpu_rdata[c*DATA_W +: DATA_W] = pool_rdata[int'(rp_q)*DATA_W +: DATA_W];

        assert_read_ret_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (cpu_gnt[c] && !cpu_we[c]) |=> cpu_rvalid[c]);
    end

    assert_ram_prio_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req == 2'b11 && cpu_cache == 2'b00 && cpu_pool[0] == cpu_pool[1]
         && role_q[int'(cpu_pool[0])*ROLE_W +: ROLE_W] == ROLE_RAM)
        |-> (cpu_gnt == 2'b01));

    assert_pool_drive_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_gnt != '0) |-> (pool_en != '0));
endmodule

// File: rtl/cache_pool_mux.sv
// Module: cache_pool_mux (top)
// Connects the mode/enable configuration to the access router for two CPUs
// and two memory pools. The pool roles are registered in cpm_cfg, so an owner
// changes only on a clock edge. The cache tag logic is outside this block.
module cache_pool_mux
    import cpm_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               mode_wr,
    input  logic [1:0]         mode_wdata,
    input  logic [1:0]         cache_req,
    input  logic [1:0]         cpu_req,
    input  logic [1:0]         cpu_cache,
    input  logic [1:0]         cpu_pool,
    input  logic [1:0]         cpu_we,
    input  logic [2*ADDR_W-1:0] cpu_addr,
    input  logic [2*DATA_W-1:0] cpu_wdata,
    output logic [1:0]         cpu_gnt,
    output logic [1:0]         cpu_rvalid,
    output logic [2*DATA_W-1:0] cpu_rdata,
    output logic [1:0]         pool_en,
    output logic [1:0]         pool_we,
    output logic [2*ADDR_W-1:0] pool_addr,
    output logic [2*DATA_W-1:0] pool_wdata,
    input  logic [2*DATA_W-1:0] pool_rdata,
    output logic [3:0]         pool_role,
    output logic [1:0]         mode_q,
    output logic [1:0]         cache_on,
    output logic               cfg_err
);
    cpm_cfg u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_wr    (mode_wr),
        .mode_wdata (mode_wdata),
        .cache_req  (cache_req),
        .mode_q     (mode_q),
        .cache_on   (cache_on),
        .role_q     (pool_role),
        .cfg_err    (cfg_err)
    );

    cpm_router #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_router (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_q     (mode_q),
        .role_q     (pool_role),
        .cpu_req    (cpu_req),
        .cpu_cache  (cpu_cache),
        .cpu_pool   (cpu_pool),
        .cpu_we     (cpu_we),
        .cpu_addr   (cpu_addr),
        .cpu_wdata  (cpu_wdata),
        .cpu_gnt    (cpu_gnt),
        .cpu_rvalid (cpu_rvalid),
        .cpu_rdata  (cpu_rdata),
        .pool_en    (pool_en),
        .pool_we    (pool_we),
        .pool_addr  (pool_addr),
        .pool_wdata (pool_wdata),
        .pool_rdata (pool_rdata)
    );
endmodule

// File: tb/cache_pool_mux_bench.sv
// Bench: directed corner cases, then seeded random traffic, all checked
// against a behavioural model built from the requirements.
module cache_pool_mux_bench;
    localparam int AW = 12;
    localparam int DW = 32;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst_n, mode_wr;
    logic [1:0] mode_wdata, cache_req, cpu_req, cpu_cache, cpu_pool, cpu_we;
    logic [2*AW-1:0] cpu_addr;
    logic [2*DW-1:0] cpu_wdata, pool_rdata;
    logic [1:0] cpu_gnt, cpu_rvalid, pool_en, pool_we, mode_q, cache_on;
    logic [2*DW-1:0] cpu_rdata, pool_wdata;
    logic [2*AW-1:0] pool_addr;
    logic [3:0] pool_role;
    logic cfg_err;

    cache_pool_mux #(.ADDR_W(AW), .DATA_W(DW)) u_cache_pool_mux (.*);

    // Staged stimulus and model state
    bit st_rst, st_mwr;
    bit [1:0] st_mdata, st_creq, st_req, st_cache, st_pool, st_we;
    bit [2*AW-1:0] st_addr;
    bit [2*DW-1:0] st_wdata, st_rdata;
    bit [1:0] m_mode, m_en, e_tgt, e_gnt, e_rv, e_rp;
    bit m_err, do_chk;
    int n_chk = 0, n_fail = 0;

    task automatic chk(input bit good, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!good) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit [1:0] f_role(bit [1:0] m, bit [1:0] en, int p);
        if (m == 2'd1 || m == 2'd2) begin
            if (p != ((m == 2'd2) ? 1 : 0)) return 2'd0;
            if (en[0]) return 2'd1;
            if (en[1]) return 2'd2;
            return 2'd0;
        end
        return en[p] ? 2'(p + 1) : 2'd0;
    endfunction

    function automatic bit f_cpool(bit [1:0] m, int c);
        if (m == 2'd1) return 1'b0;
        if (m == 2'd2) return 1'b1;
        return 1'(c);
    endfunction

    task automatic check_all(input logic [3:0] snap);
        bit [1:0] ok;
        string rtag;
        rtag = (m_mode == 2'd3) ? "R6" : ((m_mode == 2'd0) ? "R2" : "R3");
        for (int c = 0; c < 2; c++) begin
            e_tgt[c] = st_cache[c] ? f_cpool(m_mode, c) : st_pool[c];
            ok[c] = st_req[c] && (f_role(m_mode, m_en, int'(e_tgt[c])) == (st_cache[c] ? 2'(c + 1) : 2'd0));
        end
        e_gnt[0] = ok[0];
        e_gnt[1] = ok[1] && !(ok[0] && e_tgt[0] == e_tgt[1]);
        chk(mode_q == m_mode, "R5 mode", mode_q, m_mode);
        chk(cfg_err == m_err, "R5 err", cfg_err, m_err);
        chk(cache_on == m_en, (m_mode == 1 || m_mode == 2) ? "R4 enables" : "R2 enables", cache_on, m_en);
        chk(pool_role == snap, "R7 role moved mid-cycle", pool_role, snap);
        for (int p = 0; p < 2; p++)
            chk(pool_role[2*p +: 2] == f_role(m_mode, m_en, p), rtag, pool_role[2*p +: 2], f_role(m_mode, m_en, p));
        for (int c = 0; c < 2; c++) begin
            chk(cpu_gnt[c] == e_gnt[c], st_cache[c] ? "R8 gnt" : "R9 gnt", cpu_gnt[c], e_gnt[c]);
            chk(cpu_rvalid[c] == e_rv[c], "R10 rvalid", cpu_rvalid[c], e_rv[c]);
            if (e_rv[c])
                chk(cpu_rdata[c*DW +: DW] == st_rdata[int'(e_rp[c])*DW +: DW], "R10 rdata",
                    cpu_rdata[c*DW +: DW], st_rdata[int'(e_rp[c])*DW +: DW]);
        end
        for (int p = 0; p < 2; p++) begin
            bit h0, h1;
            int s;
            h0 = e_gnt[0] && e_tgt[0] == 1'(p);
            h1 = e_gnt[1] && e_tgt[1] == 1'(p);
            chk(pool_en[p] == (h0 | h1), "R11 pool_en", pool_en[p], h0 | h1);
            if (h0 | h1) begin
                s = h0 ? 0 : 1;
                chk(pool_addr[p*AW +: AW] == st_addr[s*AW +: AW] && pool_we[p] == st_we[s] &&
                    pool_wdata[p*DW +: DW] == st_wdata[s*DW +: DW], "R8 pool fields",
                    {pool_we[p], pool_addr[p*AW +: AW]}, {st_we[s], st_addr[s*AW +: AW]});
            end
        end
    endtask

    task automatic model_step();
        bit [1:0] nm, ne;
        if (st_rst) begin
            m_mode = 0; m_en = 0; m_err = 0; e_rv = 0; e_rp = 0;
            return;
        end
        nm = m_mode;
        if (st_mwr) begin
            if (m_en == 0) nm = st_mdata; else m_err = 1;
        end
        if (!(nm == 1 || nm == 2)) ne = st_creq;
        else if (m_en[0] && st_creq[0]) begin ne = 2'b01; if (st_creq[1]) m_err = 1; end
        else if (m_en[1] && st_creq[1]) begin ne = 2'b10; if (st_creq[0]) m_err = 1; end
        else if (st_creq[0]) begin ne = 2'b01; if (st_creq[1]) m_err = 1; end
        else ne = st_creq;
        m_mode = nm; m_en = ne;
        for (int c = 0; c < 2; c++) begin
            e_rv[c] = e_gnt[c] && !st_we[c];
            e_rp[c] = e_tgt[c];
        end
    endtask

    // One clock cycle: junk inputs, snapshot roles, real inputs, check, edge
    task automatic cyc();
        logic [3:0] snap;
        @(negedge clk);
        cache_req = 2'($urandom); mode_wr = 1'($urandom); mode_wdata = 2'($urandom);
        #1 snap = pool_role;
        #1;
        rst_n = !st_rst; mode_wr = st_mwr; mode_wdata = st_mdata; cache_req = st_creq;
        cpu_req = st_req; cpu_cache = st_cache; cpu_pool = st_pool; cpu_we = st_we;
        cpu_addr = st_addr; cpu_wdata = st_wdata; pool_rdata = st_rdata;
        #1;
        if (do_chk) check_all(snap);
        @(posedge clk);
        model_step();
    endtask

    task automatic idle();
        st_rst = 0; st_mwr = 0; st_req = 0; st_cache = 0; st_pool = 0; st_we = 0;
    endtask

    task automatic do_reset();
        idle(); st_creq = 0; st_rst = 1; cyc(); st_rst = 0;
    endtask

    task automatic settle();
        #2;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #(8 * 200000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd2718));
        do_chk = 0; idle(); st_creq = 0; st_mdata = 0; st_addr = 0; st_wdata = 0; st_rdata = 0;
        st_rst = 1; cyc(); cyc();
        do_chk = 1; idle(); cyc(); settle();
        chk(mode_q == 0 && cache_on == 0 && pool_role == 0 && cfg_err == 0, "R1 reset state",
            {mode_q, cache_on, pool_role, cfg_err}, 0);

        // R2: mode 0, both caches on
        st_creq = 2'b11; cyc(); cyc(); settle();
        chk(pool_role == 4'b1001, "R2 private roles", pool_role, 4'b1001);
        // R5: mode write while a cache is on is refused
        st_mwr = 1; st_mdata = 2'd1; cyc(); idle(); cyc(); settle();
        chk(mode_q == 0 && cfg_err == 1, "R5 locked mode", {mode_q, cfg_err}, 3'b001);

        // R6: mode 3 written together with enables acts as mode 0
        do_reset(); settle();
        chk(cfg_err == 0, "R1 error cleared", cfg_err, 0);
        st_mwr = 1; st_mdata = 2'd3; st_creq = 2'b11; cyc(); idle(); cyc(); settle();
        chk(mode_q == 3 && pool_role == 4'b1001, "R6 mode3 roles", {mode_q, pool_role}, 6'b111001);

        // R4: simultaneous enable in mode 1, CPU0 wins, then handover
        do_reset();
        st_mwr = 1; st_mdata = 2'd1; cyc(); idle();
        st_creq = 2'b11; cyc(); cyc(); settle();
        chk(cache_on == 2'b01 && cfg_err == 1 && pool_role == 4'b0001, "R4 CPU0 wins",
            {cache_on, cfg_err, pool_role}, 7'b0110001);
        st_req = 2'b11; st_cache = 2'b10; st_pool = 2'b10; cyc();
        st_creq = 2'b10; idle(); cyc(); cyc(); settle();
        chk(cache_on == 2'b10 && pool_role == 4'b0010, "R4 handover", {cache_on, pool_role}, 6'b100010);

        // R3/R9: mode 2, pool 0 free as RAM, both CPUs target it
        do_reset();
        st_mwr = 1; st_mdata = 2'd2; cyc(); idle();
        st_creq = 2'b01; cyc(); cyc(); settle();
        chk(pool_role == 4'b0100, "R3 mode2 roles", pool_role, 4'b0100);
        st_req = 2'b11; st_cache = 2'b00; st_pool = 2'b00; st_addr = 24'hABC123; st_rdata = {32'h1111, 32'h2222};
        cyc(); cyc(); idle(); cyc();

        // Random phase
        do_reset();
        for (int i = 0; i < 4000; i++) begin
            st_rst = (i % 300 == 299);
            st_mwr = ($urandom % 12 == 0);
            st_mdata = 2'($urandom);
            if ($urandom % 6 == 0) st_creq[0] = ~st_creq[0];
            if ($urandom % 6 == 0) st_creq[1] = ~st_creq[1];
            st_req = 2'($urandom); st_cache = 2'($urandom); st_pool = 2'($urandom); st_we = 2'($urandom);
            st_addr = {12'($urandom), 12'($urandom)};
            st_wdata = {$urandom, $urandom};
            st_rdata = {$urandom, $urandom};
            cyc();
        end
        finish_run();
    end
endmodule